// File: doc/BRIEF.md
# Two-Write Write-Once-Memory Codec

This block encodes and decodes a rewriting code for binary storage cells that can only be programmed from 0 to 1 until they are erased. Each symbol group holds two data bits in three cells and can be written twice before an erase, which gives 4/3 data bits per cell over one erase cycle. A word carries `GROUPS` independent symbol groups, all processed in parallel.

The write channel takes the new data, the cell contents read back from the array just before the write, and a flag saying whether this is the first or the second write since erase. It returns the cell pattern to program and a per-group error bit. On the second write, if the stored value already equals the new data, the cells are left as they are. Otherwise the complement codeword is used, which only ever adds set cells. The read channel turns a cell pattern back into data.

Both channels are valid/ready streams with one register stage each, and they are fully independent. An input is taken on a clock edge where its valid and ready are both high. An input ready is high when the channel's output register is empty or is being drained in the same cycle. A result stays valid and unchanged until its ready is seen high.

Top module: `wom2_codec`

## Requirements
- R1: A first write (`wr_second`=0) of data 00, 01, 10, 11 into a group whose cells allow it yields cells (c2 c1 c0) 000, 100, 010, 001 respectively, with the group's error bit low. Group g occupies data bits [2g+1:2g] and cell bits [3g+2:3g].
- R2: A second write (`wr_second`=1) to a group holding at most one set cell, with data different from the stored value, yields 111, 011, 101, 110 for data 00, 01, 10, 11, with the error bit low.
- R3: A second write whose data equals the value already stored in a group with at most one set cell returns that group's old cells unchanged, with the error bit low.
- R4: A write whose codeword would clear a set cell raises the group's error bit and returns the old cells of that group unchanged.
- R5: A second write to a group that already has two or more set cells raises the group's error bit and returns its old cells unchanged.
- R6: Every set cell in the old pattern is still set in the returned pattern.
- R7: A read of a group with at most one set cell decodes 000, 100, 010, 001 to 00, 01, 10, 11. A group with two or more set cells decodes 111, 011, 101, 110 to 00, 01, 10, 11.
- R8: Each group is encoded on its own: an error in one group changes neither the cells nor the error bit of any other group.
- R9: A write result appears one clock after acceptance. While `res_valid` is high and `res_ready` is low, the result holds and `wr_ready` is low.
- R10: A read result appears one clock after acceptance, holds under back-pressure, and flows regardless of the state of the write channel.
- R11: After reset, both result valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request can be taken |
| wr_second | input | 1 | 1 = second write since erase, 0 = first |
| wr_data | input | 2*GROUPS | New data, two bits per group |
| wr_cells_old | input | 3*GROUPS | Cell contents read before the write |
| res_valid | output | 1 | Write result present |
| res_ready | input | 1 | Write result consumed |
| res_cells | output | 3*GROUPS | Cell pattern to program |
| res_err | output | GROUPS | Per-group illegal write flag |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request can be taken |
| rd_cells | input | 3*GROUPS | Cell pattern to decode |
| dout_valid | output | 1 | Decoded data present |
| dout_ready | input | 1 | Decoded data consumed |
| dout_data | output | 2*GROUPS | Decoded data |

## Verification
A write and a read can both be accepted on the same edge, because the two channels share only the clock and reset. The bench drives both valids in the same cycle and then compares the encoded cells and the decoded data against independently computed values. It also stalls the write result with `res_ready` low while a read is in flight. In that case the read must complete on time while the write result and `wr_ready` stay frozen, and the stalled write must then complete with the data it was presented with.

// File: rtl/wom2_pkg.sv
package wom2_pkg;
  localparam int DBITS = 2;
  localparam int CBITS = 3;

  function automatic logic [CBITS-1:0] first_code(input logic [DBITS-1:0] d);
    logic [CBITS-1:0] c;
    case (d)
      2'b00:   c = 3'b000;
      2'b01:   c = 3'b100;
      2'b10:   c = 3'b010;
      default: c = 3'b001;
    endcase
    return c;
  endfunction

  function automatic logic [CBITS-1:0] second_code(input logic [DBITS-1:0] d);
    return ~first_code(d);
  endfunction

  function automatic logic [DBITS-1:0] undo_first(input logic [CBITS-1:0] c);
    logic [DBITS-1:0] d;
    case (c)
      3'b100:  d = 2'b01;
      3'b010:  d = 2'b10;
      3'b001:  d = 2'b11;
      default: d = 2'b00;
    endcase
    return d;
  endfunction

  function automatic logic is_heavy(input logic [CBITS-1:0] c);
    return (c[0] & c[1]) | (c[0] & c[2]) | (c[1] & c[2]);
  endfunction
endpackage

// File: rtl/wom2_sym_enc.sv
module wom2_sym_enc
  import wom2_pkg::*;
(
  input  logic [DBITS-1:0] data,
  input  logic [CBITS-1:0] old_cells,
  input  logic             second,
  output logic [CBITS-1:0] new_cells,
  output logic             err
);
  logic [CBITS-1:0] cand;
  logic             bad;
  logic             heavy;
  logic [DBITS-1:0] stored;

  always_comb begin
    heavy  = is_heavy(old_cells);
    stored = undo_first(old_cells);
    bad    = 1'b0;
    cand   = first_code(data);
    if (second) begin
      if (heavy)                bad  = 1'b1;
      else if (stored == data)  cand = old_cells;
      else                      cand = second_code(data);
    end
    if ((old_cells & ~cand) != '0) bad = 1'b1;
    new_cells = bad ? old_cells : cand;
    err       = bad;
  end
endmodule

// File: rtl/wom2_sym_dec.sv
module wom2_sym_dec
  import wom2_pkg::*;
(
  input  logic [CBITS-1:0] cells,
  output logic [DBITS-1:0] data
);
  always_comb begin
    if (is_heavy(cells)) data = undo_first(~cells);
    else                 data = undo_first(cells);
  end
endmodule

// File: rtl/wom2_pipe_reg.sv
module wom2_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/wom2_codec.sv
module wom2_codec
  import wom2_pkg::*;
#(
  parameter int GROUPS = 8,
  localparam int DW = GROUPS * DBITS,
  localparam int CW = GROUPS * CBITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_second,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] wr_cells_old,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [CW-1:0] res_cells,
  output logic [GROUPS-1:0] res_err,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [CW-1:0] rd_cells,
  output logic          dout_valid,
  input  logic          dout_ready,
  output logic [DW-1:0] dout_data
);
  localparam int WRW = CW + GROUPS;

  logic [CW-1:0]     enc_cells;
  logic [GROUPS-1:0] enc_err;
  logic [DW-1:0]     dec_data;
  logic [WRW-1:0]    wr_pay;

  for (genvar g = 0; g < GROUPS; g++) begin : g_sym
    wom2_sym_enc u_enc (
      .data      (wr_data[g*DBITS +: DBITS]),
      .old_cells (wr_cells_old[g*CBITS +: CBITS]),
      .second    (wr_second),
      .new_cells (enc_cells[g*CBITS +: CBITS]),
      .err       (enc_err[g])
    );
    wom2_sym_dec u_dec (
      .cells (rd_cells[g*CBITS +: CBITS]),
      .data  (dec_data[g*DBITS +: DBITS])
    );
  end

  wom2_pipe_reg #(.W(WRW)) u_wr_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .in_data   ({enc_err, enc_cells}),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (wr_pay)
  );
  assign res_cells = wr_pay[CW-1:0];
  assign res_err   = wr_pay[WRW-1:CW];

  wom2_pipe_reg #(.W(DW)) u_rd_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rd_valid),
    .in_ready  (rd_ready),
    .in_data   (dec_data),
    .out_valid (dout_valid),
    .out_ready (dout_ready),
    .out_data  (dout_data)
  );
endmodule

// File: rtl/wom2_codec_chk.sv
module wom2_codec_chk #(
  parameter int GROUPS = 8,
  localparam int DW = GROUPS * 2,
  localparam int CW = GROUPS * 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_second,
  input logic [DW-1:0] wr_data,
  input logic [CW-1:0] wr_cells_old,
  input logic          res_valid,
  input logic          res_ready,
  input logic [CW-1:0] res_cells,
  input logic [GROUPS-1:0] res_err,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [CW-1:0] rd_cells,
  input logic          dout_valid,
  input logic          dout_ready,
  input logic [DW-1:0] dout_data
);
  p_monotone_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> ((res_cells & $past(wr_cells_old)) == $past(wr_cells_old)));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_cells) && $stable(res_err)));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> !wr_ready);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  p_rd_flow_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> dout_valid);

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && !dout_valid && wr_ready && rd_ready));

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    p_err_keep_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_ready) |=>
        (!res_err[g] || (res_cells[g*3 +: 3] == $past(wr_cells_old[g*3 +: 3]))));
  end
endmodule

bind wom2_codec wom2_codec_chk #(.GROUPS(GROUPS)) u_chk (.*);

// File: tb/wom2_codec_test.sv
module wom2_codec_test;
  localparam int G  = 8;
  localparam int DW = 2 * G;
  localparam int CW = 3 * G;

  // {first data, second data, cells after first, cells after second}
  localparam logic [9:0] VEC [16] = '{
    10'b00_00_000_000, 10'b00_01_000_011, 10'b00_10_000_101, 10'b00_11_000_110,
    10'b01_00_100_111, 10'b01_01_100_100, 10'b01_10_100_101, 10'b01_11_100_110,
    10'b10_00_010_111, 10'b10_01_010_011, 10'b10_10_010_010, 10'b10_11_010_110,
    10'b11_00_001_111, 10'b11_01_001_011, 10'b11_10_001_101, 10'b11_11_001_001
  };

  logic clk = 1'b0;
  logic rst;
  logic wr_valid, wr_ready, wr_second;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] wr_cells_old;
  logic res_valid, res_ready;
  logic [CW-1:0] res_cells;
  logic [G-1:0] res_err;
  logic rd_valid, rd_ready;
  logic [CW-1:0] rd_cells;
  logic dout_valid, dout_ready;
  logic [DW-1:0] dout_data;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  wom2_codec #(.GROUPS(G)) uut (.*);

  function automatic logic [2:0] comp_code(input logic [1:0] d);
    case (d)
      2'b00:   return 3'b111;
      2'b01:   return 3'b011;
      2'b10:   return 3'b101;
      default: return 3'b110;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic sec, input logic [DW-1:0] d, input logic [CW-1:0] old,
                            output logic [CW-1:0] cells, output logic [G-1:0] err);
    @(negedge clk);
    wr_valid = 1'b1; wr_second = sec; wr_data = d; wr_cells_old = old; res_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(res_valid, "R9 write result valid", 64'(res_valid), 64'd1);
    cells = res_cells;
    err   = res_err;
  endtask

  task automatic read_word(input logic [CW-1:0] cells, output logic [DW-1:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_cells = cells; dout_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(dout_valid, "R10 read result valid", 64'(dout_valid), 64'd1);
    d = dout_data;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d1w, d2w, d3w, rdv;
    logic [CW-1:0] e1w, e2w, e3w, c1, c2, c3;
    logic [G-1:0]  er, e3err;

    rst = 1'b1; wr_valid = 0; wr_second = 0; wr_data = '0; wr_cells_old = '0;
    res_ready = 0; rd_valid = 0; rd_cells = '0; dout_ready = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!res_valid && !dout_valid, "R11 valids low after reset", {res_valid, dout_valid}, 0);
    chk(wr_ready && rd_ready, "R11 readies high after reset", {wr_ready, rd_ready}, 3);

    for (int i = 0; i < 16; i++) begin
      for (int g = 0; g < G; g++) begin
        logic [9:0] v;
        v = VEC[(i + g) % 16];
        d1w[2*g +: 2] = v[9:8];
        d2w[2*g +: 2] = v[7:6];
        e1w[3*g +: 3] = v[5:3];
        e2w[3*g +: 3] = v[2:0];
        d3w[2*g +: 2] = v[7:6] ^ 2'b01;
        if ($countones(v[2:0]) >= 2) begin
          e3w[3*g +: 3] = v[2:0];
          e3err[g] = 1'b1;
        end else begin
          e3w[3*g +: 3] = comp_code(v[7:6] ^ 2'b01);
          e3err[g] = 1'b0;
        end
      end
      write_word(1'b0, d1w, '0, c1, er);
      chk(c1 == e1w, "R1 first write cells", c1, e1w);
      chk(er == '0, "R1 first write error", er, 0);
      read_word(c1, rdv);
      chk(rdv == d1w, "R7 read after first write", rdv, d1w);
      write_word(1'b1, d2w, c1, c2, er);
      chk(c2 == e2w, "R2 R3 second write cells", c2, e2w);
      chk(er == '0, "R2 second write error", er, 0);
      chk((c2 & c1) == c1, "R6 cells only set", c2, c1);
      read_word(c2, rdv);
      chk(rdv == d2w, "R7 read after second write", rdv, d2w);
      write_word(1'b1, d3w, c2, c3, er);
      chk(c3 == e3w, "R5 extra second write cells", c3, e3w);
      chk(er == e3err, "R5 extra second write error", er, e3err);
    end

    // R4 and R8: group 0 first-write 10 over 100 is illegal; others write 01 legally
    write_word(1'b0, {{(G-1){2'b01}}, 2'b10}, {{(G-1){3'b000}}, 3'b100}, c1, er);
    chk(c1 == {G{3'b100}}, "R4 R8 illegal group kept, others written", c1, {G{3'b100}});
    chk(er == {{(G-1){1'b0}}, 1'b1}, "R4 R8 error only in group 0", er, 1);

    // R9 and R10: write stalled while a read flows
    @(negedge clk);
    res_ready = 1'b0; wr_valid = 1'b1; wr_second = 1'b0;
    wr_data = {G{2'b00}}; wr_cells_old = '0;
    @(negedge clk);
    chk(res_valid && res_cells == '0, "R9 first result", res_cells, 0);
    wr_data = {G{2'b11}};
    rd_valid = 1'b1; rd_cells = {G{3'b110}}; dout_ready = 1'b1;
    @(negedge clk);
    chk(!wr_ready, "R9 ready low under back-pressure", wr_ready, 0);
    chk(res_valid && res_cells == '0, "R9 result held", res_cells, 0);
    chk(dout_valid && dout_data == {G{2'b11}}, "R10 read flows during write stall", dout_data, {G{2'b11}});
    rd_valid = 1'b0; res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid && res_cells == {G{3'b001}}, "R9 stalled write completes", res_cells, {G{3'b001}});
    wr_valid = 1'b0;
    @(negedge clk);
    chk(!res_valid, "R9 result drained", res_valid, 0);

    // R10: write and read accepted on the same edge
    @(negedge clk);
    wr_valid = 1'b1; wr_second = 1'b1; wr_data = {G{2'b10}}; wr_cells_old = {G{3'b100}};
    rd_valid = 1'b1; rd_cells = {G{3'b010}};
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    chk(res_valid && res_cells == {G{3'b101}}, "R10 R2 same-cycle write", res_cells, {G{3'b101}});
    chk(dout_valid && dout_data == {G{2'b10}}, "R10 R7 same-cycle read", dout_data, {G{2'b10}});

    // R10: read result held while dout_ready low
    @(negedge clk);
    dout_ready = 1'b0; rd_valid = 1'b1; rd_cells = {G{3'b001}};
    @(negedge clk);
    rd_cells = {G{3'b000}};
    @(negedge clk);
    chk(dout_valid && dout_data == {G{2'b11}}, "R10 read held", dout_data, {G{2'b11}});
    chk(!rd_ready, "R10 read ready low under back-pressure", rd_ready, 0);
    rd_valid = 1'b0; dout_ready = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule